// File: doc/BRIEF.md
# Programmable Crossbar I/O Port Cell

This cell joins one external pin to one line of an internal switch matrix. A 4-bit mode code picks how data may cross between the two sides. The cell can pass data straight through in either direction, or through a flip-flop. It can also act as a transceiver with separate direction enables, tie one side to a constant, or isolate the pin from the array. The pin and the array line are each modelled as three signals: an incoming value, an outgoing value and a drive enable. The tri-state resolution of the real wires sits outside the cell.

Three more configuration bits apply to every mode that honours them. One makes the active-high input enable take effect, one makes the active-low output enable take effect, and one inverts the data sent to the pin in the two output modes. The registered modes share the block clock. A synchronous active-high reset clears both flip-flops. While reset is asserted it also makes the cell behave as no-connect, whatever mode code is applied.

Top module: `xio_cell`

## Requirements
- R1: While `rst` is high, `pin_oe` and `arr_oe` are 0. A clock edge with `rst` high clears both data flip-flops, so in a registered mode the registered output is 0 until the next edge after reset is released.
- R2: Mode 1 (input) drives `arr_out` with `pin_in` and sets `arr_oe`=1 when `cfg_use_ie`=0, or when `cfg_use_ie`=1 and `ie`=1. `pin_oe` stays 0.
- R3: When an output enable is 0, its data output is 0: `arr_oe`=0 implies `arr_out`=0. In modes 1, 3, 8 and 9 with `cfg_use_ie`=1 and `ie`=0, `arr_oe` is 0.
- R4: Mode 2 (output) drives `pin_out` with `arr_in` XOR `cfg_invert`. It sets `pin_oe`=1 when `cfg_use_oe`=0, or when `cfg_use_oe`=1 and `oe_n`=0. `arr_oe` stays 0.
- R5: `pin_oe`=0 implies `pin_out`=0. In modes 2, 4, 6 and 7 with `cfg_use_oe`=1 and `oe_n`=1, `pin_oe` is 0.
- R6: Mode 3 (registered input) drives `arr_out` with the value `pin_in` had at the previous rising clock edge. `arr_oe` is gated as in R2.
- R7: Mode 4 (registered output) drives `pin_out` with the value `arr_in` had at the previous rising edge, XOR `cfg_invert`. `pin_oe` is gated as in R4.
- R8: Mode 5 (transceiver) uses both enables regardless of `cfg_use_ie`/`cfg_use_oe`: `arr_oe`=`ie` and `pin_oe`=NOT `oe_n`. `arr_out` carries `pin_in`. `pin_out` carries `arr_in` when `ie`=0 and `pin_in` when `ie`=1 (pin-to-array has priority). `cfg_invert` has no effect.
- R9: Modes 6 and 7 drive `pin_out` to the constant 0 and 1 respectively, independent of `arr_in`. `pin_oe` is gated as in R4 and `arr_oe`=0.
- R10: Modes 8 and 9 drive `arr_out` to the constant 0 and 1 respectively, independent of `pin_in`. `arr_oe` is gated as in R2 and `pin_oe`=0.
- R11: Mode 0 (no connect) and the unused codes 10 to 15 hold `pin_oe`, `arr_oe`, `pin_out` and `arr_out` at 0 for any other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered modes |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 4 | Mode code |
| cfg_use_ie | input | 1 | Make the input enable take effect |
| cfg_use_oe | input | 1 | Make the output enable take effect |
| cfg_invert | input | 1 | Invert pin data in modes 2 and 4 |
| ie | input | 1 | Input enable, active high |
| oe_n | input | 1 | Output enable, active low |
| pin_in | input | 1 | Value seen on the external pin |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin drive enable |
| arr_in | input | 1 | Value seen on the matrix line |
| arr_out | output | 1 | Value driven onto the matrix line |
| arr_oe | output | 1 | Matrix line drive enable |

## Verification
The hardest case to reach is the transceiver with both enables active. The pin output then has to follow the pin input rather than the matrix line, and this only shows when the two data inputs differ while `ie`=1 and `oe_n`=0. The stimulus sweeps every combination of the seven data, enable and option bits in each mode code, so this case occurs with both possible disagreements. The registered modes are driven with a changing pattern. Each pattern is sampled once before the capturing edge and once after it, to show the one-cycle delay. Right after reset release, the flip-flop is shown to still hold 0 even though the pin input is 1.

// File: rtl/xio_pkg.sv
package xio_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] XM_NC    = 4'd0;
    localparam logic [MODE_W-1:0] XM_IN    = 4'd1;
    localparam logic [MODE_W-1:0] XM_OUT   = 4'd2;
    localparam logic [MODE_W-1:0] XM_RIN   = 4'd3;
    localparam logic [MODE_W-1:0] XM_ROUT  = 4'd4;
    localparam logic [MODE_W-1:0] XM_BIDIR = 4'd5;
    localparam logic [MODE_W-1:0] XM_PF0   = 4'd6;
    localparam logic [MODE_W-1:0] XM_PF1   = 4'd7;
    localparam logic [MODE_W-1:0] XM_AF0   = 4'd8;
    localparam logic [MODE_W-1:0] XM_AF1   = 4'd9;

    // how a drive enable is formed
    typedef enum logic [1:0] {
        GATE_OFF = 2'd0,   // never drives
        GATE_OPT = 2'd1,   // enable honoured only when its use bit is set
        GATE_REQ = 2'd2    // enable always honoured
    } gate_e;

    typedef enum logic [1:0] {
        ASRC_PIN = 2'd0,
        ASRC_REG = 2'd1,
        ASRC_LO  = 2'd2,
        ASRC_HI  = 2'd3
    } arr_src_e;

    typedef enum logic [2:0] {
        PSRC_ARR   = 3'd0,
        PSRC_REG   = 3'd1,
        PSRC_LO    = 3'd2,
        PSRC_HI    = 3'd3,
        PSRC_BIDIR = 3'd4
    } pin_src_e;

    typedef struct packed {
        gate_e    arr_gate;
        arr_src_e arr_src;
        gate_e    pin_gate;
        pin_src_e pin_src;
        logic     inv_ok;
    } xio_ctl_t;

    localparam xio_ctl_t CTL_ISOLATE = '{
        arr_gate: GATE_OFF, arr_src: ASRC_LO,
        pin_gate: GATE_OFF, pin_src: PSRC_LO,
        inv_ok:   1'b0
    };

    function automatic logic gate_eval(gate_e g, logic use_en, logic en_act);
        logic r;
        case (g)
            GATE_OPT: r = use_en ? en_act : 1'b1;
            GATE_REQ: r = en_act;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/xio_decode.sv
module xio_decode
    import xio_pkg::*;
(
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    output xio_ctl_t          ctl
);

    always_comb begin
        ctl = CTL_ISOLATE;
        if (!rst) begin
            case (mode)
                XM_IN: begin
                    ctl.arr_gate = GATE_OPT;
                    ctl.arr_src  = ASRC_PIN;
                end
                XM_OUT: begin
                    ctl.pin_gate = GATE_OPT;
                    ctl.pin_src  = PSRC_ARR;
                    ctl.inv_ok   = 1'b1;
                end
                XM_RIN: begin
                    ctl.arr_gate = GATE_OPT;
                    ctl.arr_src  = ASRC_REG;
                end
                XM_ROUT: begin
                    ctl.pin_gate = GATE_OPT;
                    ctl.pin_src  = PSRC_REG;
                    ctl.inv_ok   = 1'b1;
                end
                XM_BIDIR: begin
                    ctl.arr_gate = GATE_REQ;
                    ctl.arr_src  = ASRC_PIN;
                    ctl.pin_gate = GATE_REQ;
                    ctl.pin_src  = PSRC_BIDIR;
                end
                XM_PF0: begin
                    ctl.pin_gate = GATE_OPT;
                    ctl.pin_src  = PSRC_LO;
                end
                XM_PF1: begin
                    ctl.pin_gate = GATE_OPT;
                    ctl.pin_src  = PSRC_HI;
                end
                XM_AF0: begin
                    ctl.arr_gate = GATE_OPT;
                    ctl.arr_src  = ASRC_LO;
                end
                XM_AF1: begin
                    ctl.arr_gate = GATE_OPT;
                    ctl.arr_src  = ASRC_HI;
                end
                default: ctl = CTL_ISOLATE;
            endcase
        end
    end

endmodule

// File: rtl/xio_regs.sv
module xio_regs #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_pin,
    input  logic [W-1:0] d_arr,
    output logic [W-1:0] q_pin,
    output logic [W-1:0] q_arr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_pin <= '0;
            q_arr <= '0;
        end else begin
            q_pin <= d_pin;
            q_arr <= d_arr;
        end
    end

    // R1: reset clears both capture flops
    p_clear_r1: assert property (@(posedge clk) rst |=> (q_pin == '0 && q_arr == '0));

endmodule

// File: rtl/xio_cell.sv
module xio_cell
    import xio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              cfg_use_ie,
    input  logic              cfg_use_oe,
    input  logic              cfg_invert,
    input  logic              ie,
    input  logic              oe_n,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    input  logic              arr_in,
    output logic              arr_out,
    output logic              arr_oe
);

    xio_ctl_t ctl;
    logic     in_q, out_q;
    logic     arr_en, pin_en;
    logic     arr_val, pin_val;

    xio_decode u_decode (
        .rst  (rst),
        .mode (cfg_mode),
        .ctl  (ctl)
    );

    xio_regs #(.W(1)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .d_pin (pin_in),
        .d_arr (arr_in),
        .q_pin (in_q),
        .q_arr (out_q)
    );

    always_comb begin
        arr_en = gate_eval(ctl.arr_gate, cfg_use_ie, ie);
        pin_en = gate_eval(ctl.pin_gate, cfg_use_oe, !oe_n);

        case (ctl.arr_src)
            ASRC_PIN: arr_val = pin_in;
            ASRC_REG: arr_val = in_q;
            ASRC_HI:  arr_val = 1'b1;
            default:  arr_val = 1'b0;
        endcase

        case (ctl.pin_src)
            PSRC_ARR:   pin_val = arr_in;
            PSRC_REG:   pin_val = out_q;
            PSRC_HI:    pin_val = 1'b1;
            // pin-to-array wins: with both directions open the line carries the pin
            PSRC_BIDIR: pin_val = arr_en ? pin_in : arr_in;
            default:    pin_val = 1'b0;
        endcase
        pin_val = pin_val ^ (ctl.inv_ok & cfg_invert);
    end

    assign arr_oe  = arr_en;
    assign arr_out = arr_en & arr_val;
    assign pin_oe  = pin_en;
    assign pin_out = pin_en & pin_val;

    // R1: no drive while reset is held
    p_rst_quiet_r1: assert property (@(posedge clk) rst |-> (!pin_oe && !arr_oe));

    // R3 / R5: undriven outputs rest low
    p_arr_low_r3: assert property (@(posedge clk) disable iff (rst) !arr_oe |-> !arr_out);
    p_pin_low_r5: assert property (@(posedge clk) disable iff (rst) !pin_oe |-> !pin_out);

    // R6: registered input delays one edge
    p_rin_delay_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && cfg_mode == XM_RIN && arr_oe) |-> (arr_out == $past(pin_in)));

    // R7: registered output delays one edge and honours inversion
    p_rout_delay_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && cfg_mode == XM_ROUT && pin_oe) |-> (pin_out == ($past(arr_in) ^ cfg_invert)));

    // R8: transceiver follows both enables directly
    p_bidir_en_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == XM_BIDIR) |-> (arr_oe == ie && pin_oe == !oe_n));

    // R11: no-connect and unused codes isolate
    p_iso_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == XM_NC || cfg_mode > XM_AF1) |-> (!pin_oe && !arr_oe));

endmodule

// File: tb/xio_cell_tb.sv
module xio_cell_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        string tag;
        logic  p_out, p_oe, a_out, a_oe;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cfg_mode = 4'd0;
    logic       cfg_use_ie = 1'b0, cfg_use_oe = 1'b0, cfg_invert = 1'b0;
    logic       ie = 1'b0, oe_n = 1'b1, pin_in = 1'b0, arr_in = 1'b0;
    logic       pin_out, pin_oe, arr_out, arr_oe;

    logic       mdl_in_q = 1'b0, mdl_out_q = 1'b0;
    item_t      sb_q[$];
    event       ev_sample;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xio_cell u_dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode),
        .cfg_use_ie(cfg_use_ie), .cfg_use_oe(cfg_use_oe), .cfg_invert(cfg_invert),
        .ie(ie), .oe_n(oe_n),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .arr_in(arr_in), .arr_out(arr_out), .arr_oe(arr_oe)
    );

    // reference flops from R1, R6, R7
    always @(posedge clk) begin
        mdl_in_q  <= rst ? 1'b0 : pin_in;
        mdl_out_q <= rst ? 1'b0 : arr_in;
    end

    function automatic item_t predict(string tag);
        item_t e;
        logic ig, og;
        ig = cfg_use_ie ? ie : 1'b1;
        og = cfg_use_oe ? !oe_n : 1'b1;
        e.tag = tag; e.p_out = 0; e.p_oe = 0; e.a_out = 0; e.a_oe = 0;
        if (!rst) begin
            case (cfg_mode)
                4'd1: begin e.a_oe = ig; e.a_out = pin_in; end
                4'd2: begin e.p_oe = og; e.p_out = arr_in ^ cfg_invert; end
                4'd3: begin e.a_oe = ig; e.a_out = mdl_in_q; end
                4'd4: begin e.p_oe = og; e.p_out = mdl_out_q ^ cfg_invert; end
                4'd5: begin
                    e.a_oe = ie; e.a_out = pin_in;
                    e.p_oe = !oe_n; e.p_out = ie ? pin_in : arr_in;
                end
                4'd6: begin e.p_oe = og; e.p_out = 1'b0; end
                4'd7: begin e.p_oe = og; e.p_out = 1'b1; end
                4'd8: begin e.a_oe = ig; e.a_out = 1'b0; end
                4'd9: begin e.a_oe = ig; e.a_out = 1'b1; end
                default: ;
            endcase
        end
        e.a_out = e.a_out & e.a_oe;
        e.p_out = e.p_out & e.p_oe;
        return e;
    endfunction

    function automatic string tag_for();
        case (cfg_mode)
            4'd1:    return (cfg_use_ie && !ie) ? "R3" : "R2";
            4'd2:    return (cfg_use_oe && oe_n) ? "R5" : "R4";
            4'd3:    return "R6";
            4'd4:    return "R7";
            4'd5:    return "R8";
            4'd6, 4'd7: return "R9";
            4'd8, 4'd9: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(string tag);
        sb_q.push_back(predict(tag));
        ->ev_sample;
        #1;
    endtask

    // monitor: pops the expected item and compares with the outputs
    initial begin
        forever begin
            @(ev_sample);
            while (sb_q.size() > 0) begin
                item_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (pin_out !== e.p_out || pin_oe !== e.p_oe ||
                    arr_out !== e.a_out || arr_oe !== e.a_oe) begin
                    n_errors++;
                    $display("FAIL %s mode=%0d: got pin_out=%b pin_oe=%b arr_out=%b arr_oe=%b exp %b %b %b %b",
                             e.tag, cfg_mode, pin_out, pin_oe, arr_out, arr_oe,
                             e.p_out, e.p_oe, e.a_out, e.a_oe);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // R1: reset in registered input mode with pin high
        cfg_mode = 4'd3; pin_in = 1'b1; rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); #2 chk("R1");
        rst = 1'b0;
        #2 chk("R1");                    // flop still 0 after release
        @(posedge clk); #2 chk("R6");    // now captured 1

        // combinational sweep of every mode code and input combination
        for (int m = 0; m < 16; m++) begin
            if (m == 3 || m == 4) continue;
            cfg_mode = m[3:0];
            for (int c = 0; c < 128; c++) begin
                @(negedge clk);
                pin_in = c[0]; arr_in = c[1]; ie = c[2]; oe_n = c[3];
                cfg_use_ie = c[4]; cfg_use_oe = c[5]; cfg_invert = c[6];
                #2 chk(tag_for());
            end
        end

        // registered modes: before and after the capturing edge
        for (int m = 3; m < 5; m++) begin
            cfg_mode = m[3:0];
            for (int i = 0; i < 48; i++) begin
                @(negedge clk);
                pin_in = i[0] ^ i[2]; arr_in = i[1] ^ i[0];
                cfg_invert = i[3]; cfg_use_ie = i[4]; cfg_use_oe = i[4];
                ie = i[5] | i[1]; oe_n = i[5] & i[2];
                #2 chk(tag_for());
                @(posedge clk); #2 chk(tag_for());
            end
        end

        // reset while active mode forces quiet outputs
        @(negedge clk);
        cfg_mode = 4'd5; ie = 1'b1; oe_n = 1'b0; rst = 1'b1;
        #2 chk("R1");
        @(posedge clk); #2 chk("R1");

        done = 1'b1;
        #5;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule